// File: doc/BRIEF.md
# Mask First-Hit Prefix Generator

This block builds a new destination mask from a source mask by finding the lowest-numbered active element whose source bit is set. It supports three ways of shaping the result around that element. In set-before mode the bits strictly below it are set. In set-including mode the bits up to and including it are set. In set-only mode only that single bit is set. Each element is active when it lies in the body (index below the vector length) and, if masking is enabled, its execution-mask bit is 1. Inactive body elements and tail elements keep the value of the old destination.

The caller pulses `start` with all operands valid. One clock later the result appears on `vd_new` together with a one-cycle `dirty` pulse, which tells the register file that vector state has changed. The caller is responsible for the legality checks: the start index is zero, the destination does not overlap the source, and the destination is not the mask register when masking is on. `vd_new` holds its value until the next `start`.

Top module: `mskfirst_gen`

## Requirements
- R1: After reset `vd_new` is all zeros and `dirty` is 0.
- R2: `vd_new` changes only in the cycle after a `start` pulse. With `start` low it holds its value, whatever the other inputs do.
- R3: `dirty` is 1 in the cycle after `start` when `mode` is 0, 1 or 2. It is 0 at all other times, including after a `start` with `mode` 3.
- R4: With `mode` 0 (set-before), an active element gets 1 when no lower active element has a set source bit and its own source bit is 0. Every other active element gets 0.
- R5: With `mode` 1 (set-including), an active element gets 1 when no lower active element has a set source bit, whatever its own source bit. Every other active element gets 0.
- R6: With `mode` 2 (set-only), an active element gets 1 only when it is the lowest active element with a set source bit. Every other active element gets 0.
- R7: When `vm` is 0, a body element whose `v0` bit is 0 is inactive. It keeps its `vd_old` bit, and its source bit does not count as the first hit.
- R8: Elements with index at or above `vl` keep their `vd_old` bits.
- R9: `mode` 3 is reserved. It makes `vd_new` equal to `vd_old`.
- R10: When no active element has a set source bit, modes 0 and 1 write 1 to every active element and mode 2 writes 0 to every active element.
- R11: When `vm` is 1, every element below `vl` is active, whatever `v0` holds.
- R12: With `vl` equal to 0, `vd_new` equals `vd_old` in every mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle strobe that launches an operation |
| mode | input | 2 | 0 set-before, 1 set-including, 2 set-only, 3 reserved |
| vm | input | 1 | 1: all body elements are active; 0: `v0` qualifies each element |
| vl | input | VLW | Vector length in elements, 0 to VLEN |
| vs2 | input | VLEN | Source mask |
| v0 | input | VLEN | Execution mask |
| vd_old | input | VLEN | Previous destination value |
| vd_new | output | VLEN | Registered destination result |
| dirty | output | 1 | One-cycle pulse when vector state was written |

## Verification
The assertions assume that `vl` never exceeds VLEN and that the operands are stable in the cycle when `start` is high. The comparisons between the next value and `vd_old` assume that `vd_old` is sampled in that same cycle. The bench drives every operand at the falling edge together with `start`, holds it through the capturing edge, and chooses `vl` only from 0 to VLEN. It sweeps every pair of source and execution masks of a six-element configuration in all four modes. It then changes the operands while `start` is low, which checks that these changes leave the result alone.

// File: rtl/mskfirst_pkg.sv
package mskfirst_pkg;

  typedef enum logic [1:0] {
    MF_BEFORE = 2'd0,
    MF_INCL   = 2'd1,
    MF_ONLY   = 2'd2,
    MF_RSVD   = 2'd3
  } mf_mode_e;

  // Value written to one active element, given whether an active hit
  // exists strictly below it and the element's own source bit.
  function automatic logic mf_bit(mf_mode_e m, logic seen_below, logic src);
    logic r;
    case (m)
      MF_BEFORE: r = ~seen_below & ~src;
      MF_INCL:   r = ~seen_below;
      MF_ONLY:   r = ~seen_below & src;
      default:   r = 1'b0;
    endcase
    return r;
  endfunction

  function automatic logic mf_mode_writes(mf_mode_e m);
    return m != MF_RSVD;
  endfunction

endpackage

// File: rtl/mskfirst_active.sv
module mskfirst_active #(
  parameter int VLEN = 64,
  parameter int VLW  = $clog2(VLEN + 1)
) (
  input  logic            vm,
  input  logic [VLW-1:0]  vl,
  input  logic [VLEN-1:0] v0,
  output logic [VLEN-1:0] body,
  output logic [VLEN-1:0] act
);
  for (genvar i = 0; i < VLEN; i++) begin : g_elem
    localparam logic [VLW-1:0] IDX = VLW'(i);
    assign body[i] = IDX < vl;
    assign act[i]  = body[i] & (vm | v0[i]);
  end
endmodule

// File: rtl/mskfirst_prefix.sv
module mskfirst_prefix #(
  parameter int VLEN = 64
) (
  input  logic [VLEN-1:0] hit,
  output logic [VLEN-1:0] seen_below,
  output logic            any_hit
);
  // Exclusive prefix-OR: seen_below[i] = |hit[i-1:0]
  assign seen_below[0] = 1'b0;
  for (genvar i = 1; i < VLEN; i++) begin : g_chain
    assign seen_below[i] = seen_below[i-1] | hit[i-1];
  end
  assign any_hit = seen_below[VLEN-1] | hit[VLEN-1];
endmodule

// File: rtl/mskfirst_select.sv
module mskfirst_select
  import mskfirst_pkg::*;
#(
  parameter int VLEN = 64
) (
  input  mf_mode_e        mode,
  input  logic [VLEN-1:0] act,
  input  logic [VLEN-1:0] seen_below,
  input  logic [VLEN-1:0] vs2,
  input  logic [VLEN-1:0] vd_old,
  output logic [VLEN-1:0] nxt
);
  logic writes;
  assign writes = mf_mode_writes(mode);

  for (genvar i = 0; i < VLEN; i++) begin : g_bit
    assign nxt[i] = (writes && act[i]) ? mf_bit(mode, seen_below[i], vs2[i])
                                       : vd_old[i];
  end
endmodule

// File: rtl/mskfirst_gen.sv
module mskfirst_gen
  import mskfirst_pkg::*;
#(
  parameter int VLEN = 64,
  parameter int VLW  = $clog2(VLEN + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [1:0]      mode,
  input  logic            vm,
  input  logic [VLW-1:0]  vl,
  input  logic [VLEN-1:0] vs2,
  input  logic [VLEN-1:0] v0,
  input  logic [VLEN-1:0] vd_old,
  output logic [VLEN-1:0] vd_new,
  output logic            dirty
);
  mf_mode_e        mode_e;
  logic [VLEN-1:0] body, act, hit, seen_below, nxt;
  logic            any_hit;

  assign mode_e = mf_mode_e'(mode);
  assign hit    = act & vs2;

  mskfirst_active #(.VLEN(VLEN), .VLW(VLW)) u_active (
    .vm(vm), .vl(vl), .v0(v0), .body(body), .act(act)
  );

  mskfirst_prefix #(.VLEN(VLEN)) u_prefix (
    .hit(hit), .seen_below(seen_below), .any_hit(any_hit)
  );

  mskfirst_select #(.VLEN(VLEN)) u_select (
    .mode(mode_e), .act(act), .seen_below(seen_below), .vs2(vs2),
    .vd_old(vd_old), .nxt(nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vd_new <= '0;
      dirty  <= 1'b0;
    end else begin
      dirty <= start && mf_mode_writes(mode_e);
      if (start) vd_new <= nxt;
    end
  end

  // R2: result holds without a start strobe
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(vd_new));

  // R3: dirty follows a start with a writing mode
  a_r3_dirty: assert property (@(posedge clk) disable iff (!rst_n)
    (start && mode != 2'd3) |=> dirty);
  a_r3_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(start && mode != 2'd3) |=> !dirty);

  // R6: set-only marks at most one active element
  a_r6_single: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2) |-> $onehot0(nxt & act));

  // R7: inactive elements keep the old bit
  a_r7_inactive_keep: assert property (@(posedge clk) disable iff (!rst_n)
    ((nxt ^ vd_old) & ~act) == '0);

  // R8: tail elements keep the old bit
  a_r8_tail_keep: assert property (@(posedge clk) disable iff (!rst_n)
    ((nxt ^ vd_old) & ~body) == '0);

  // R9: reserved mode copies the old destination
  a_r9_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (start && mode == 2'd3) |=> vd_new == $past(vd_old));

  // R10: no active hit fills or clears the active set
  a_r10_none_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_hit && (mode == 2'd0 || mode == 2'd1)) |-> (nxt & act) == act);
  a_r10_none_only: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_hit && mode == 2'd2) |-> (nxt & act) == '0);
endmodule

// File: tb/mskfirst_gen_test.sv
module mskfirst_gen_test;
  localparam int VLEN = 6;
  localparam int VLW  = 3;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic [1:0]      mode = '0;
  logic            vm = 1'b0;
  logic [VLW-1:0]  vl = '0;
  logic [VLEN-1:0] vs2 = '0, v0 = '0, vd_old = '0;
  logic [VLEN-1:0] vd_new;
  logic            dirty;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  mskfirst_gen #(.VLEN(VLEN), .VLW(VLW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .vm(vm), .vl(vl),
    .vs2(vs2), .v0(v0), .vd_old(vd_old), .vd_new(vd_new), .dirty(dirty)
  );

  // Sequential reference walk over the elements
  function automatic logic [VLEN-1:0] ref_vd(input logic [1:0] m, input logic vmf,
      input int len, input logic [VLEN-1:0] s, input logic [VLEN-1:0] msk,
      input logic [VLEN-1:0] old);
    logic [VLEN-1:0] r = old;
    bit found = 0;
    if (m == 2'd3) return old;
    for (int i = 0; i < VLEN; i++) begin
      if (i < len && (vmf || msk[i])) begin
        case (m)
          2'd0: r[i] = !found && !s[i];
          2'd1: r[i] = !found;
          default: r[i] = !found && s[i];
        endcase
        if (s[i]) found = 1;
      end
    end
    return r;
  endfunction

  function automatic string mode_tag(input logic [1:0] m);
    case (m)
      2'd0: return "R4";
      2'd1: return "R5";
      2'd2: return "R6";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string tag, input logic [VLEN-1:0] got,
      input logic [VLEN-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", tag, got, exp);
    end
  endtask

  task automatic run_op(input string tag, input logic [1:0] m, input logic vmf,
      input int len, input logic [VLEN-1:0] s, input logic [VLEN-1:0] msk,
      input logic [VLEN-1:0] old);
    logic [VLEN-1:0] exp;
    @(negedge clk);
    mode = m; vm = vmf; vl = VLW'(len); vs2 = s; v0 = msk; vd_old = old;
    start = 1'b1;
    exp = ref_vd(m, vmf, len, s, msk, old);
    @(negedge clk);
    start = 1'b0;
    check({tag, " result"}, vd_new, exp);
    check({"R3 dirty (", tag, ")"}, {{(VLEN-1){1'b0}}, dirty},
          {{(VLEN-1){1'b0}}, (m != 2'd3)});
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    logic [VLEN-1:0] held;
    repeat (3) @(negedge clk);
    // R1: reset values
    check("R1 vd_new reset", vd_new, '0);
    check("R1 dirty reset", {{(VLEN-1){1'b0}}, dirty}, '0);
    rst_n = 1'b1;

    // Masked sweep: every vs2/v0 pair in every mode (R4 R5 R6 R7 R8 R9)
    for (int s = 0; s < 64; s++)
      for (int k = 0; k < 64; k++)
        for (int m = 0; m < 4; m++)
          run_op({mode_tag(2'(m)), " R7 R8"}, 2'(m), 1'b0, (s * 5 + k * 3 + m) % 7,
                 6'(s), 6'(k), 6'(s) ^ 6'(k << 1) ^ 6'(m * 9));

    // R11: unmasked, v0 contents irrelevant
    for (int s = 0; s < 64; s++)
      for (int len = 0; len <= VLEN; len++)
        for (int m = 0; m < 4; m++)
          run_op("R11", 2'(m), 1'b1, len, 6'(s), 6'(~s), 6'(s * 7 + len));

    // R10: no active hit
    for (int m = 0; m < 3; m++) begin
      run_op("R10 zero src", 2'(m), 1'b1, VLEN, '0, '0, 6'b101010);
      run_op("R10 hits only inactive", 2'(m), 1'b0, VLEN, 6'b010101, 6'b101010, 6'b010101);
    end

    // R12: empty body
    for (int m = 0; m < 4; m++)
      run_op("R12 vl zero", 2'(m), 1'b1, 0, 6'b111111, 6'b111111, 6'b100110);

    // R2: operands move without start, result holds
    held = vd_new;
    for (int j = 0; j < 8; j++) begin
      @(negedge clk);
      mode = 2'(j); vm = j[0]; vl = VLW'(j % 7);
      vs2 = 6'(j * 11); v0 = 6'(j * 13); vd_old = 6'(~j);
      @(negedge clk);
      check("R2 hold", vd_new, held);
      check("R3 quiet", {{(VLEN-1){1'b0}}, dirty}, '0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule